// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block decides whether a 10 Mb/s twisted-pair transmitter may send frames. A receive front end reports each normal link pulse it detects as a one-cycle strobe and flags receive data activity. The monitor counts properly spaced pulses and declares the link good once enough of them have arrived. It keeps the link good while pulses or receive data keep coming in, and drops it when both have been absent for a programmable time.

Regardless of link state, the block also produces a periodic one-cycle strobe that asks the transmit side to send its own link pulse. A configuration input can turn the link test off. The transmitter is then always allowed to send, while `link_ok` still shows what the monitor has seen.

All timing thresholds are inputs counted in clock cycles, so the same logic serves any clock rate. The minimum pulse spacing, the link-loss time and the pulse period are programmed that way, and so is the number of pulses needed to qualify the link.

Top module: `lnk_integrity_mon`

## Requirements
- R1: `lp_strobe` is high for exactly one cycle every P cycles, where P is `pulse_period`, and a value of 0 is treated as 1. It is first high after the P-th rising edge following reset release. This holds whatever `test_en`, the link state or the received traffic.
- R2: While reset is held, and right after it, `link_ok`, `tx_enable` and `lp_strobe` are low.
- R3: With `test_en` high and the link down, `link_ok` and `tx_enable` rise at the clock edge that captures the N-th counted pulse. N is `qual_cnt` (4 bits) clamped into the range 2 to 7: values 0 and 1 give 2, and 8 to 15 give 7.
- R4: A pulse is counted only if at least `min_gap` edges separate it from the previous pulse of any kind, or if no pulse has been seen since reset. A pulse that comes earlier resets the qualification count to zero.
- R5: While the link is up, each counted pulse and each cycle with `rx_active` high restarts the loss timer, so the link stays up.
- R6: If L edges pass after the last restart with no further restart, the link drops at the L-th edge, where L is `loss_limit` and 0 is treated as 1. `link_ok` falls at that edge, and so does `tx_enable` when `test_en` is high. Early pulses do not restart the timer.
- R7: After the link drops, qualification starts again from a count of zero.
- R8: At each edge, `tx_enable` takes the value (not `test_en`) OR (the link state after that edge). With `test_en` low, `tx_enable` is therefore high from the first edge after reset with no pulses at all, and `link_ok` still follows the monitored link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_det | input | 1 | One-cycle strobe per detected incoming link pulse |
| rx_active | input | 1 | Receive data activity present this cycle |
| test_en | input | 1 | Link test enabled when high |
| qual_cnt | input | 4 | Pulses needed to qualify the link (clamped 2..7) |
| min_gap | input | TW | Minimum edges between pulses for a pulse to count |
| loss_limit | input | TW | Edges without keepalive before the link fails |
| pulse_period | input | TW | Edges between outgoing pulse requests |
| link_ok | output | 1 | Monitored link state |
| tx_enable | output | 1 | Transmitter allowed to send |
| lp_strobe | output | 1 | One-cycle request to send an outgoing link pulse |

## Verification
The hardest situation to reach is an early pulse that arrives partway through qualification. It must wipe the count, and the bench has to prove that afterwards exactly N fresh pulses are needed. The bench reaches it by placing a pulse one cycle short of `min_gap` between counted pulses, then counting the edges until `link_ok` rises. A stream of early pulses on an up link is used the same way, to show that such pulses do not keep the link alive. Exact drop edges are found by ending the keepalive on a known edge and sampling one edge before and at the L-th edge.

// File: rtl/lim_pkg.sv
package lim_pkg;

  typedef enum logic {LINK_DOWN = 1'b0, LINK_UP = 1'b1} link_st_e;

  // Qualifying pulse count, clamped into 2..7
  function automatic logic [2:0] qual_target(input logic [3:0] q);
    if (q < 4'd2)      return 3'd2;
    else if (q > 4'd7) return 3'd7;
    else               return q[2:0];
  endfunction

  // A programmed length of zero behaves as one
  function automatic int unsigned eff_len(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/lim_pulse_gen.sv
module lim_pulse_gen #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] period,
  output logic          strobe
);
  logic [TW-1:0] cnt;
  logic          wrap;

  assign wrap = 32'(cnt) >= (lim_pkg::eff_len(32'(period)) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= wrap;
      cnt    <= wrap ? '0 : cnt + 1'b1;
    end
  end

  AST_STROBE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (cnt == '0)); // R1

endmodule

// File: rtl/lim_gap_filter.sv
module lim_gap_filter #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_det,
  input  logic [TW-1:0] min_gap,
  output logic          valid_pulse,
  output logic          early_pulse
);
  // Edges since the previous pulse, saturating; all ones means "none seen"
  logic [TW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)              gap <= '1;
    else if (pulse_det)      gap <= TW'(1);
    else if (gap != '1)      gap <= gap + 1'b1;
  end

  assign valid_pulse = pulse_det && (gap >= min_gap);
  assign early_pulse = pulse_det && !valid_pulse;

  AST_GAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_det |=> (gap == TW'(1))); // R4

endmodule

// File: rtl/lim_loss_timer.sv
module lim_loss_timer #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up,
  input  logic          kick,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] loss_cnt;

  assign expire = link_up && !kick &&
                  (32'(loss_cnt) >= (lim_pkg::eff_len(32'(limit)) - 32'd1));

  always_ff @(posedge clk) begin
    if (!rst_n)                       loss_cnt <= '0;
    else if (!link_up || kick || expire) loss_cnt <= '0;
    else                              loss_cnt <= loss_cnt + 1'b1;
  end

  AST_LOSS_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (loss_cnt == '0)); // R6
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (loss_cnt == '0)); // R5

endmodule

// File: rtl/lnk_integrity_mon.sv
module lnk_integrity_mon #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_det,
  input  logic          rx_active,
  input  logic          test_en,
  input  logic [3:0]    qual_cnt,
  input  logic [TW-1:0] min_gap,
  input  logic [TW-1:0] loss_limit,
  input  logic [TW-1:0] pulse_period,
  output logic          link_ok,
  output logic          tx_enable,
  output logic          lp_strobe
);
  import lim_pkg::*;

  // Named internal events
  logic             valid_pulse;
  logic             early_pulse;
  logic             keepalive;
  logic             expire;
  logic             qual_reach;
  logic [2:0]       target;
  link_st_e         link_q, link_nxt;
  logic [2:0]       qcnt, qcnt_nxt;
  logic             tx_q;

  lim_pulse_gen #(.TW(TW)) u_pgen (
    .clk(clk), .rst_n(rst_n), .period(pulse_period), .strobe(lp_strobe));

  lim_gap_filter #(.TW(TW)) u_gap (
    .clk(clk), .rst_n(rst_n), .pulse_det(pulse_det), .min_gap(min_gap),
    .valid_pulse(valid_pulse), .early_pulse(early_pulse));

  assign keepalive = valid_pulse || rx_active;

  lim_loss_timer #(.TW(TW)) u_loss (
    .clk(clk), .rst_n(rst_n), .link_up(link_q == LINK_UP), .kick(keepalive),
    .limit(loss_limit), .expire(expire));

  assign target     = qual_target(qual_cnt);
  assign qual_reach = valid_pulse && (({1'b0, qcnt} + 4'd1) >= {1'b0, target});

  always_comb begin
    link_nxt = link_q;
    qcnt_nxt = qcnt;
    if (link_q == LINK_UP) begin
      qcnt_nxt = '0;
      if (expire) link_nxt = LINK_DOWN;
    end else if (early_pulse) begin
      qcnt_nxt = '0;
    end else if (valid_pulse) begin
      if (qual_reach) begin
        link_nxt = LINK_UP;
        qcnt_nxt = '0;
      end else begin
        qcnt_nxt = qcnt + 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= LINK_DOWN;
      qcnt   <= '0;
      tx_q   <= 1'b0;
    end else begin
      link_q <= link_nxt;
      qcnt   <= qcnt_nxt;
      tx_q   <= !test_en || (link_nxt == LINK_UP);
    end
  end

  assign link_ok   = (link_q == LINK_UP);
  assign tx_enable = tx_q;

  AST_RISE_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ok) |-> $past(valid_pulse)); // R3
  AST_QCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt < 3'd7); // R3
  AST_EARLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    early_pulse |=> (qcnt == '0)); // R4
  AST_KEEPALIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ok && keepalive) |=> link_ok); // R5
  AST_FALL_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ok) |-> $past(expire)); // R6
  AST_DROP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (qcnt == '0 && !link_ok)); // R7
  AST_BYPASS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> tx_enable); // R8

endmodule

// File: tb/test_lnk_integrity_mon.sv
module test_lnk_integrity_mon;
  localparam int TW = 24;
  localparam int G  = 4;
  localparam int L  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pulse_det = 1'b0;
  logic          rx_active = 1'b0;
  logic          test_en = 1'b1;
  logic [3:0]    qual_cnt = 4'd2;
  logic [TW-1:0] min_gap = TW'(G);
  logic [TW-1:0] loss_limit = TW'(L);
  logic [TW-1:0] pulse_period = TW'(1000);
  logic          link_ok, tx_enable, lp_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lnk_integrity_mon #(.TW(TW)) i_lnk_integrity_mon (
    .clk(clk), .rst_n(rst_n), .pulse_det(pulse_det), .rx_active(rx_active),
    .test_en(test_en), .qual_cnt(qual_cnt), .min_gap(min_gap),
    .loss_limit(loss_limit), .pulse_period(pulse_period),
    .link_ok(link_ok), .tx_enable(tx_enable), .lp_strobe(lp_strobe));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse();
    pulse_det = 1'b1; step(); pulse_det = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pulse_det = 1'b0; rx_active = 1'b0;
    wait_n(2);
    chk("R2 link_ok", link_ok, 0);
    chk("R2 tx_enable", tx_enable, 0);
    chk("R2 lp_strobe", lp_strobe, 0);
    rst_n = 1'b1;
  endtask

  function automatic int clamp_q(input int q);
    return (q < 2) ? 2 : (q > 7) ? 7 : q;
  endfunction

  // Bring the link up with tgt pulses spaced G edges apart
  task automatic qualify(input int tgt);
    for (int i = 1; i <= tgt; i++) begin
      if (i > 1) wait_n(G - 1);
      pulse();
    end
  endtask

  initial begin
    // R1: period sweep, both test_en values
    for (int te = 0; te < 2; te++) begin
      for (int p = 0; p <= 6; p++) begin
        pulse_period = TW'(p);
        test_en = te[0];
        do_reset();
        for (int n = 1; n <= 30; n++) begin
          step();
          chk("R1 strobe", lp_strobe, (n % ((p == 0) ? 1 : p)) == 0 ? 1 : 0);
        end
      end
    end
    pulse_period = TW'(1000);
    test_en = 1'b1;

    // R3: qualification count sweep with clamping
    for (int q = 0; q < 16; q++) begin
      int tgt;
      qual_cnt = 4'(q);
      tgt = clamp_q(q);
      do_reset();
      for (int i = 1; i <= tgt; i++) begin
        if (i > 1) wait_n(G - 1);
        pulse();
        chk("R3 link_ok", link_ok, (i == tgt) ? 1 : 0);
        chk("R3 tx_enable", tx_enable, (i == tgt) ? 1 : 0);
      end
    end

    // R4: early pulse mid-qualification clears the count
    qual_cnt = 4'd3;
    do_reset();
    pulse(); wait_n(G - 1); pulse();
    wait_n(G - 2); pulse();
    chk("R4 early not up", link_ok, 0);
    wait_n(G - 1); pulse(); chk("R4 count1", link_ok, 0);
    wait_n(G - 1); pulse(); chk("R4 count2", link_ok, 0);
    wait_n(G - 1); pulse(); chk("R4 count3 up", link_ok, 1);

    // R6: loss after L idle edges; R7: requalify from zero
    do_reset();
    qualify(3);
    wait_n(L - 1);
    chk("R6 still up", link_ok, 1);
    step();
    chk("R6 dropped", link_ok, 0);
    chk("R6 tx dropped", tx_enable, 0);
    qualify(2);
    chk("R7 two not enough", link_ok, 0);
    wait_n(G - 1); pulse();
    chk("R7 requalified", link_ok, 1);

    // R5: receive activity keeps the link alive
    do_reset();
    qualify(3);
    rx_active = 1'b1;
    wait_n(50);
    rx_active = 1'b0;
    chk("R5 rx keepalive", link_ok, 1);
    wait_n(L - 1);
    chk("R5 rx up before loss", link_ok, 1);
    step();
    chk("R6 drop after rx", link_ok, 0);

    // R5: counted pulses keep the link alive
    do_reset();
    qualify(3);
    for (int k = 0; k < 15; k++) begin
      wait_n(G - 1); pulse();
      chk("R5 pulse keepalive", link_ok, 1);
    end
    wait_n(L - 1);
    chk("R5 up before loss", link_ok, 1);
    step();
    chk("R6 drop after pulses", link_ok, 0);

    // R6: early pulses do not keep the link alive
    do_reset();
    qualify(3);
    for (int k = 0; k < 12; k++) begin
      wait_n(G - 2); pulse();
    end
    chk("R6 early no keepalive", link_ok, 0);

    // R8: bypass
    test_en = 1'b0;
    qual_cnt = 4'd2;
    do_reset();
    step();
    chk("R8 tx bypass", tx_enable, 1);
    chk("R8 link_ok still down", link_ok, 0);
    pulse(); wait_n(G - 1); pulse();
    chk("R8 link_ok monitored", link_ok, 1);
    wait_n(L);
    chk("R8 link_ok dropped", link_ok, 0);
    chk("R8 tx stays", tx_enable, 1);
    test_en = 1'b1; step();
    chk("R8 tx follows link", tx_enable, 0);
    test_en = 1'b0; step();
    chk("R8 tx bypass again", tx_enable, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule